// File: doc/BRIEF.md
# Register-Mapped Serial Port Controller

This block is the register side of a simple serial port. A processor reaches eight 32-bit registers through a small register bus with a word address, separate read and write strobes and 32-bit data. Bytes that arrive from the line side come in on a valid/ready byte stream. They are held in a receive FIFO until software reads them, and bytes written by software leave on a transmit byte stream. A single level interrupt line combines three status conditions under a 3-bit software mask.

A companion DMA channel sits beside the block. Software loads a receive destination address and a receive byte count. While that count is nonzero, bytes are steered away from the FIFO to a byte-write port for the DMA channel. Bytes already waiting in the FIFO go out on that port first, oldest first, and only then are new stream bytes accepted. A write of the transmit count raises a one-cycle start pulse carrying the transmit address and length, and the stored transmit address advances by that length. Baud timing, framing and the memory-moving engine itself live outside this block.

Top module: `serial_port_ctrl`

## Requirements
- R1: The bus word address is the byte address shifted right by two. Word address 0 reads the identification constant 0xC51D0001.
- R2: A read of word address 1 (DATA) removes the oldest FIFO byte and returns it zero-extended, in arrival order. Read data appears on `bus_rdata` one cycle after the read strobe is sampled.
- R3: A DATA read while the FIFO is empty returns 0xFFFFFFFF and leaves the FIFO occupancy unchanged.
- R4: A write to DATA produces a one-cycle `tx_valid` pulse on the following cycle, with `tx_data` equal to bits 7:0 of the written word.
- R5: Word address 2 reads the FIFO occupancy (default depth 16). While the FIFO holds `DEPTH` bytes and the receive count is zero, `rx_ready` is low and occupancy never exceeds `DEPTH`.
- R6: Word address 3 holds the interrupt mask: a write keeps only bits 2:0 and a read returns them, with bits 31:3 zero.
- R7: The status vector is bit0 = FIFO not empty, bit1 = transmit DMA done (always 1), bit2 = receive count equal to zero. `irq` is high exactly when status AND mask is nonzero.
- R8: While the receive count (word address 7) is nonzero and the FIFO is empty, each accepted stream byte goes out on the DMA write port at the current receive address (word address 6). The address then increments by one and the count decrements by one, and the byte is not stored.
- R9: When the receive count is made nonzero while the FIFO holds bytes, those bytes leave on the DMA write port one per cycle, oldest first, ahead of any new stream byte. `rx_ready` stays low until the FIFO is empty.
- R10: A write to word address 5 gives a one-cycle `dma_tx_start` pulse on the next cycle, with `dma_tx_addr` equal to the transmit address (word address 4) and `dma_tx_len` equal to the written value. The stored transmit address then advances by that value, and word address 5 always reads 0.
- R11: Any word address with a nonzero bit above bit 2 reads 0, and writes to such an address change nothing.
- R12: After reset the FIFO is empty, the mask, both addresses and the receive count are zero, `irq` and `tx_valid` are low and `rx_ready` is high.
- R13: A DATA read and a FIFO push in the same cycle both take effect and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_waddr | input | AW | Word address (byte address >> 2) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Incoming byte accepted when high with valid |
| tx_valid | output | 1 | Outgoing byte valid pulse |
| tx_data | output | 8 | Outgoing byte |
| dma_rx_idle | output | 1 | Receive count equals zero |
| dma_wr_valid | output | 1 | Byte for the DMA channel valid |
| dma_wr_addr | output | 32 | Destination address for that byte |
| dma_wr_data | output | 8 | Byte for the DMA channel |
| dma_tx_start | output | 1 | Transmit DMA start pulse |
| dma_tx_addr | output | 32 | Transmit source address with the pulse |
| dma_tx_len | output | 32 | Transmit length with the pulse |

## Verification
Register read data, `tx_valid` and `dma_tx_start` come one cycle after the rising edge that samples their strobe. A byte steered from the stream shows on the DMA port in the same cycle it is offered, and FIFO drain bytes follow in the cycles after the count write. `irq` and `rx_ready` follow the registered state, so they change one cycle after the edge that changes that state. The bench drives inputs just after a rising edge and samples on the falling edge. A monitor pops the expected read word, transmit byte, DMA byte or start pulse from its queues whenever the matching output is due.

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl #(
  parameter int          DEPTH   = 16,
  parameter int          AW      = 10,
  parameter logic [31:0] ID_WORD = 32'hC51D0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_waddr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          dma_rx_idle,
  output logic          dma_wr_valid,
  output logic [31:0]   dma_wr_addr,
  output logic [7:0]    dma_wr_data,
  output logic          dma_tx_start,
  output logic [31:0]   dma_tx_addr,
  output logic [31:0]   dma_tx_len
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] I_ID = 3'd0, I_DATA = 3'd1, I_CNT = 3'd2, I_MASK = 3'd3,
                         I_TXA = 3'd4, I_TXC = 3'd5, I_RXA = 3'd6, I_RXC = 3'd7;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [2:0]    mask;
  logic [31:0]   tx_addr, rx_addr, rx_cnt, rd_val;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire       hit        = (bus_waddr[AW-1:3] == '0);
  wire [2:0] idx        = bus_waddr[2:0];
  wire       wr_hit     = bus_wr & hit;
  wire       fifo_empty = (occ == '0);
  wire       fifo_full  = (occ == CW'(DEPTH));
  wire       rx_idle    = (rx_cnt == '0);
  wire       rd_data    = bus_rd & hit & (idx == I_DATA);
  wire       pop_bus    = rd_data & ~fifo_empty;
  wire       drain      = ~rx_idle & ~fifo_empty & ~rd_data;
  wire       take       = rx_valid & rx_ready;
  wire       push       = take & rx_idle;
  wire       steer      = take & ~rx_idle;
  wire       pop        = pop_bus | drain;
  wire [2:0] stat       = {rx_idle, 1'b1, ~fifo_empty};

  assign rx_ready     = rx_idle ? ~fifo_full : fifo_empty;
  assign dma_rx_idle  = rx_idle;
  assign dma_wr_valid = drain | steer;
  assign dma_wr_data  = drain ? mem[rd_ptr] : rx_data;
  assign dma_wr_addr  = rx_addr;
  assign irq          = |(stat & mask);

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (idx)
        I_ID:    rd_val = ID_WORD;
        I_DATA:  rd_val = fifo_empty ? 32'hFFFF_FFFF : {24'b0, mem[rd_ptr]};
        I_CNT:   rd_val = 32'(occ);
        I_MASK:  rd_val = {29'b0, mask};
        I_TXA:   rd_val = tx_addr;
        I_TXC:   rd_val = '0;
        I_RXA:   rd_val = rx_addr;
        default: rd_val = rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      occ          <= '0;
      mask         <= '0;
      tx_addr      <= '0;
      rx_addr      <= '0;
      rx_cnt       <= '0;
      bus_rdata    <= '0;
      tx_valid     <= 1'b0;
      tx_data      <= '0;
      dma_tx_start <= 1'b0;
      dma_tx_addr  <= '0;
      dma_tx_len   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      occ <= occ + CW'(push) - CW'(pop);

      if (bus_rd) bus_rdata <= rd_val;

      tx_valid     <= wr_hit && idx == I_DATA;
      dma_tx_start <= wr_hit && idx == I_TXC;
      if (wr_hit && idx == I_DATA) tx_data <= bus_wdata[7:0];
      if (wr_hit && idx == I_MASK) mask <= bus_wdata[2:0];

      if (wr_hit && idx == I_TXA) tx_addr <= bus_wdata;
      else if (wr_hit && idx == I_TXC) begin
        dma_tx_addr <= tx_addr;
        dma_tx_len  <= bus_wdata;
        tx_addr     <= tx_addr + bus_wdata;
      end

      if (wr_hit && idx == I_RXC) rx_cnt <= bus_wdata;
      else if (dma_wr_valid)      rx_cnt <= rx_cnt - 1'b1;

      if (wr_hit && idx == I_RXA) rx_addr <= bus_wdata;
      else if (dma_wr_valid)      rx_addr <= rx_addr + 1'b1;
    end
  end
endmodule

// File: rtl/serial_port_ctrl_chk.sv
module serial_port_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              bus_waddr,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic [31:0]                bus_wdata,
  input logic [31:0]                bus_rdata,
  input logic                       irq,
  input logic                       rx_valid,
  input logic [7:0]                 rx_data,
  input logic                       rx_ready,
  input logic                       tx_valid,
  input logic [7:0]                 tx_data,
  input logic                       dma_rx_idle,
  input logic                       dma_wr_valid,
  input logic [7:0]                 dma_wr_data,
  input logic                       dma_tx_start,
  input logic [31:0]                dma_tx_len,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic [2:0]                 mask
);
  wire in_map = (bus_waddr[AW-1:3] == '0);
  wire [2:0] ix = bus_waddr[2:0];

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && in_map && ix == 3'd0 |=> bus_rdata == 32'hC51D0001); // R1
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && in_map && ix == 3'd1 && occ == '0 |=> bus_rdata == 32'hFFFF_FFFF); // R3
  AST_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && in_map && ix == 3'd1 |=> tx_valid && tx_data == $past(bus_wdata[7:0])); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH+1))'(DEPTH)); // R5
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    occ == ($clog2(DEPTH+1))'(DEPTH) && dma_rx_idle |-> !rx_ready); // R5
  AST_TX_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    mask[1] |-> irq); // R7
  AST_STEER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !dma_rx_idle |-> dma_wr_valid && dma_wr_data == rx_data); // R8
  AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && in_map && ix == 3'd5 |=> dma_tx_start && dma_tx_len == $past(bus_wdata)); // R10
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && dma_rx_idle && bus_rd && in_map && ix == 3'd1 && occ != '0
    |=> occ == $past(occ)); // R13
endmodule

bind serial_port_ctrl serial_port_ctrl_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid),
  .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .dma_rx_idle(dma_rx_idle), .dma_wr_valid(dma_wr_valid), .dma_wr_data(dma_wr_data),
  .dma_tx_start(dma_tx_start), .dma_tx_len(dma_tx_len), .occ(occ), .mask(mask)
);

// File: tb/serial_port_ctrl_tb_top.sv
module serial_port_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 10;
  localparam logic [AW-1:0] W_ID = 0, W_DATA = 1, W_CNT = 2, W_MASK = 3,
                            W_TXA = 4, W_TXC = 5, W_RXA = 6, W_RXC = 7;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_waddr = '0;
  logic bus_rd = 0, bus_wr = 0, rx_valid = 0;
  logic [31:0] bus_wdata = '0;
  logic [7:0] rx_data = '0;
  logic [31:0] bus_rdata, dma_wr_addr, dma_tx_addr, dma_tx_len;
  logic irq, rx_ready, tx_valid, dma_rx_idle, dma_wr_valid, dma_tx_start;
  logic [7:0] tx_data, dma_wr_data;

  serial_port_ctrl #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .dma_rx_idle(dma_rx_idle), .dma_wr_valid(dma_wr_valid), .dma_wr_addr(dma_wr_addr),
    .dma_wr_data(dma_wr_data), .dma_tx_start(dma_tx_start), .dma_tx_addr(dma_tx_addr),
    .dma_tx_len(dma_tx_len));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errors = 0;
  bit done = 0;
  logic [31:0] rd_q[$];
  string rd_tag[$];
  logic [7:0] tx_q[$];
  logic [39:0] dma_q[$];
  logic [63:0] txs_q[$];
  logic [7:0] model[$];
  logic [31:0] m_rxa = 0, m_rxc = 0;
  logic rd_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e; string t;
      e = rd_q.pop_front(); t = rd_tag.pop_front();
      chk(bus_rdata == e, t, 64'(bus_rdata), 64'(e));
    end
    if (tx_valid) begin
      logic [7:0] e;
      e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hxx;
      chk(tx_data === e, "R4 tx byte", 64'(tx_data), 64'(e));
    end
    if (dma_wr_valid) begin
      logic [39:0] e;
      e = (dma_q.size() > 0) ? dma_q.pop_front() : 40'hx;
      chk({dma_wr_addr, dma_wr_data} === e, "R8/R9 dma byte", 64'({dma_wr_addr, dma_wr_data}), 64'(e));
    end
    if (dma_tx_start) begin
      logic [63:0] e;
      e = (txs_q.size() > 0) ? txs_q.pop_front() : 64'hx;
      chk({dma_tx_addr, dma_tx_len} === e, "R10 tx start", {dma_tx_addr, dma_tx_len}, e);
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    @(posedge clk); #1; bus_waddr = a; bus_rd = 1;
    @(posedge clk); #1; bus_rd = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1; bus_waddr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1; bus_wr = 0;
  endtask

  task automatic send(input logic [7:0] b);
    if (m_rxc != 0) begin
      dma_q.push_back({m_rxa, b}); m_rxa++; m_rxc--;
    end else model.push_back(b);
    @(posedge clk); #1; rx_valid = 1; rx_data = b;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #1; rx_valid = 0;
  endtask

  task automatic pop_read(input string tag);
    logic [7:0] b;
    b = model.pop_front();
    rd(W_DATA, {24'b0, b}, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(irq == 0, "R12 irq after reset", 64'(irq), 0);
    chk(rx_ready == 1, "R12 rx_ready after reset", 64'(rx_ready), 1);
    chk(tx_valid == 0, "R12 tx_valid after reset", 64'(tx_valid), 0);
    rd(W_CNT, 0, "R12 occupancy after reset");
    rd(W_MASK, 0, "R12 mask after reset");
    rd(W_RXC, 0, "R12 rx count after reset");
    rd(W_RXA, 0, "R12 rx addr after reset");

    rd(W_ID, 32'hC51D0001, "R1 id word");
    rd(10'h008, 0, "R11 unmapped 0x08");
    rd(10'h3FF, 0, "R11 unmapped 0x3FF");
    wr(10'h00B, 32'h7);
    rd(W_MASK, 0, "R11 unmapped write ignored");
    rd(W_TXC, 0, "R10 tx count reads zero");

    rd(W_DATA, 32'hFFFF_FFFF, "R3 empty read");
    rd(W_CNT, 0, "R3 occupancy unchanged");

    tx_q.push_back(8'hA5); wr(W_DATA, 32'h1234_56A5);
    tx_q.push_back(8'h3C); wr(W_DATA, 32'h0000_003C);

    wr(W_MASK, 32'hFFFF_FFFA);
    rd(W_MASK, 32'h2, "R6 mask keeps low bits");
    @(negedge clk); chk(irq == 1, "R7 tx-done bit", 64'(irq), 1);
    wr(W_MASK, 0);
    @(negedge clk); chk(irq == 0, "R7 mask zero", 64'(irq), 0);
    wr(W_MASK, 4);
    @(negedge clk); chk(irq == 1, "R7 rx count zero bit", 64'(irq), 1);
    wr(W_MASK, 1);
    @(negedge clk); chk(irq == 0, "R7 fifo empty no irq", 64'(irq), 0);

    send(8'h11); send(8'h22); send(8'h33);
    @(negedge clk); chk(irq == 1, "R7 fifo not empty irq", 64'(irq), 1);
    rd(W_CNT, 3, "R5 occupancy three");
    pop_read("R2 first byte"); pop_read("R2 second byte"); pop_read("R2 third byte");
    @(negedge clk); chk(irq == 0, "R7 irq drops when empty", 64'(irq), 0);

    for (int i = 0; i < DEPTH; i++) send(8'(8'h40 + i));
    @(negedge clk); chk(rx_ready == 0, "R5 full stalls stream", 64'(rx_ready), 0);
    rd(W_CNT, DEPTH, "R5 occupancy full");
    pop_read("R2 pop from full");

    model.push_back(8'hEE);
    begin
      logic [7:0] h;
      h = model.pop_front();
      rd_q.push_back({24'b0, h}); rd_tag.push_back("R13 read during push");
    end
    @(posedge clk); #1;
    bus_waddr = W_DATA; bus_rd = 1; rx_valid = 1; rx_data = 8'hEE;
    @(posedge clk); #1; bus_rd = 0; rx_valid = 0;
    rd(W_CNT, DEPTH - 1, "R13 occupancy unchanged");
    while (model.size() > 0) pop_read("R2 drain order");
    rd(W_CNT, 0, "R2 drained empty");

    wr(W_RXA, 32'h1000);
    wr(W_MASK, 4);
    m_rxa = 32'h1000; m_rxc = 3;
    wr(W_RXC, 3);
    @(negedge clk); chk(irq == 0, "R7 rx count nonzero", 64'(irq), 0);
    send(8'hA1); send(8'hA2); send(8'hA3);
    @(negedge clk); chk(irq == 1, "R7 rx count back to zero", 64'(irq), 1);
    rd(W_CNT, 0, "R8 steered bytes not stored");
    rd(W_RXA, 32'h1003, "R8 rx addr advanced");
    rd(W_RXC, 0, "R8 rx count exhausted");

    send(8'hB1); send(8'hB2); send(8'hB3);
    begin
      logic [7:0] x;
      for (int i = 0; i < 2; i++) begin
        x = model.pop_front();
        dma_q.push_back({m_rxa, x}); m_rxa++;
      end
    end
    wr(W_RXC, 2);
    repeat (3) @(posedge clk);
    rd(W_CNT, 1, "R9 two bytes drained");
    rd(W_RXA, 32'h1005, "R9 rx addr after drain");
    pop_read("R9 remaining byte");

    wr(W_TXA, 32'h200);
    txs_q.push_back({32'h200, 32'd5});
    wr(W_TXC, 5);
    rd(W_TXA, 32'h205, "R10 tx addr advanced");
    rd(W_TXC, 0, "R10 tx count reads zero after start");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rd_q.size() == 0 && tx_q.size() == 0 && dma_q.size() == 0 && txs_q.size() == 0,
        "R4/R8/R10 all expected items seen",
        64'(rd_q.size() + tx_q.size() + dma_q.size() + txs_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule